// File: doc/BRIEF.md
# Single-Cycle 32-Bit Load/Store Core

This block is a small 32-bit processor that completes one instruction every clock. It fetches a word from an internal instruction store at the program counter and splits it into register, shift or immediate fields. It reads two operands from a 32-entry register file and runs them through an ALU. In the same cycle it writes the result back, reads or writes an internal data store, or redirects the program counter. There is no pipeline, so no hazard logic and no delay slot is needed.

The instruction set has register-register arithmetic and logic (add, sub, and, or, nor, slt), shifts by a constant (sll, srl), immediate forms (addi, andi, ori), word loads and stores, two compare-and-branch forms, an absolute jump and a register-indirect jump. While reset is held, the surrounding logic fills both stores through a shared load port. The core's progress can be seen on the program-counter output, the register write-back port and the store port.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low, pc_o reads 0 and neither wb_en_o nor st_en_o is high. All 32 registers reset to zero. After release, the first instruction runs from byte address 0.
- R2: When the instruction is not a taken branch or a jump, the program counter goes up by 4 on each clock.
- R3: R-type words (op 000000) select the operation with funct: add 100000, sub 100010, and 100100, or 100101, nor 100111. Fields are rs[25:21], rt[20:16], rd[15:11], shamt[10:6], funct[5:0], and the result goes to rd. Overflow is ignored.
- R4: slt (funct 101010) writes 1 to rd when rs is less than rt as signed two's-complement values, and 0 otherwise.
- R5: sll (funct 000000) and srl (funct 000010) shift rt by shamt[10:6] into rd. srl fills with zeros.
- R6: addi (op 001000) sign-extends imm[15:0]. andi (op 001100) and ori (op 001101) zero-extend it. The result goes to rt[20:16].
- R7: lw (op 100011) and sw (op 101011) use the address rs + sign-extended imm, with byte addresses and word index address[..:2]. lw writes the word to rt. sw writes rt to memory and shows the address and data on the store port. The store port never fires in the same cycle as a register write-back.
- R8: Register 0 always reads as zero. A write aimed at it is dropped and never shows on the write-back port.
- R9: beq (op 000100) branches when rs equals rt, and bne (op 000101) branches when they differ. The target is PC+4 + (sign-extended imm << 2). Otherwise the PC goes to PC+4.
- R10: j (op 000010) goes to {PC+4[31:28], instr[25:0], 00}.
- R11: jr (op 000000, funct 001000) goes to the value held in rs.
- R12: The load port writes ld_data_i into word ld_addr_i of the instruction store (ld_imem_we_i) or of the data store (ld_dmem_we_i). Running code later reads these words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_imem_we_i | input | 1 | Load-port write enable for the instruction store |
| ld_dmem_we_i | input | 1 | Load-port write enable for the data store |
| ld_addr_i | input | LD_AW | Word index for load-port writes |
| ld_data_i | input | 32 | Load-port write data |
| pc_o | output | 32 | Address of the instruction now executing |
| wb_en_o | output | 1 | Register write-back happens at the next edge |
| wb_addr_o | output | 5 | Write-back register index |
| wb_data_o | output | 32 | Write-back value |
| st_en_o | output | 1 | A store happens at the next edge |
| st_addr_o | output | 32 | Store byte address |
| st_data_o | output | 32 | Store data |

## Verification
The bench goes after the sign and extension corners. If addi zero-extended -3 or ori sign-extended 0x8001, the wrong upper half would show in the register written back. If slt compared unsigned, it would report 5 < -3. If srl shifted arithmetically, it would fill the top with ones. Negative load offsets and a backward branch to address 0 catch a missing sign extension in the address or target adder. A taken beq, a not-taken bne and a jr that leaves its neighbours unexecuted expose wrong condition polarity or wrong jump priority. Writes aimed at register 0 test that it keeps reading zero.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_BNE   = 6'h05;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_ANDI  = 6'h0C;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_SLL = 6'h00;
  localparam logic [5:0] FN_SRL = 6'h02;
  localparam logic [5:0] FN_JR  = 6'h08;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_NOR = 6'h27;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_SLT, ALU_SLL, ALU_SRL
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;    // 1: rd, 0: rt
    logic    use_imm;
    logic    imm_zext;
    alu_op_e alu_op;
    logic    mem_rd;
    logic    mem_we;
    logic    br_eq;
    logic    br_ne;
    logic    jump;
    logic    jreg;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    ctrl_o.alu_op = ALU_ADD;
    unique case (op_i)
      OP_RTYPE: begin
        ctrl_o.reg_we = 1'b1;
        ctrl_o.dst_rd = 1'b1;
        unique case (funct_i)
          FN_ADD: ctrl_o.alu_op = ALU_ADD;
          FN_SUB: ctrl_o.alu_op = ALU_SUB;
          FN_AND: ctrl_o.alu_op = ALU_AND;
          FN_OR:  ctrl_o.alu_op = ALU_OR;
          FN_NOR: ctrl_o.alu_op = ALU_NOR;
          FN_SLT: ctrl_o.alu_op = ALU_SLT;
          FN_SLL: ctrl_o.alu_op = ALU_SLL;
          FN_SRL: ctrl_o.alu_op = ALU_SRL;
          FN_JR: begin
            ctrl_o.reg_we = 1'b0;
            ctrl_o.jreg   = 1'b1;
          end
          default: ctrl_o.reg_we = 1'b0;
        endcase
      end
      OP_ADDI: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.use_imm = 1'b1;
      end
      OP_ANDI: begin
        ctrl_o.reg_we   = 1'b1;
        ctrl_o.use_imm  = 1'b1;
        ctrl_o.imm_zext = 1'b1;
        ctrl_o.alu_op   = ALU_AND;
      end
      OP_ORI: begin
        ctrl_o.reg_we   = 1'b1;
        ctrl_o.use_imm  = 1'b1;
        ctrl_o.imm_zext = 1'b1;
        ctrl_o.alu_op   = ALU_OR;
      end
      OP_LW: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.use_imm = 1'b1;
        ctrl_o.mem_rd  = 1'b1;
      end
      OP_SW: begin
        ctrl_o.use_imm = 1'b1;
        ctrl_o.mem_we  = 1'b1;
      end
      OP_BEQ:  ctrl_o.br_eq = 1'b1;
      OP_BNE:  ctrl_o.br_ne = 1'b1;
      OP_J:    ctrl_o.jump  = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREG = 32,
  parameter int XW   = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [RAW-1:0] ra_a_i,
  input  logic [RAW-1:0] ra_b_i,
  output logic [XW-1:0]  rd_a_o,
  output logic [XW-1:0]  rd_b_o,
  input  logic           we_i,
  input  logic [RAW-1:0] wa_i,
  input  logic [XW-1:0]  wd_i
);
  logic [XW-1:0] rows [NREG];

  assign rows[0] = '0;  // hardwired zero

  for (genvar g = 1; g < NREG; g++) begin : g_row
    logic [XW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           q <= '0;
      else if (we_i && wa_i == RAW'(g))      q <= wd_i;
    end
    assign rows[g] = q;
  end

  assign rd_a_o = rows[ra_a_i];
  assign rd_b_o = rows[ra_b_i];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int XW = 32,
  localparam int SW = $clog2(XW)
) (
  input  alu_op_e       op_i,
  input  logic [XW-1:0] a_i,
  input  logic [XW-1:0] b_i,
  input  logic [SW-1:0] shamt_i,
  output logic [XW-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_NOR: y_o = ~(a_i | b_i);
      ALU_SLT: y_o = {{(XW-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      ALU_SLL: y_o = b_i << shamt_i;
      ALU_SRL: y_o = b_i >> shamt_i;
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int LD_AW = ($clog2(IMEM_WORDS) > $clog2(DMEM_WORDS)) ?
                        $clog2(IMEM_WORDS) : $clog2(DMEM_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_imem_we_i,
  input  logic             ld_dmem_we_i,
  input  logic [LD_AW-1:0] ld_addr_i,
  input  logic [31:0]      ld_data_i,
  output logic [31:0]      pc_o,
  output logic             wb_en_o,
  output logic [4:0]       wb_addr_o,
  output logic [31:0]      wb_data_o,
  output logic             st_en_o,
  output logic [31:0]      st_addr_o,
  output logic [31:0]      st_data_o
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];

  logic [31:0] pc_q, pc_next, pc_plus4, br_tgt, j_tgt;
  logic [31:0] instr, rs_val, rt_val, imm_ext, alu_b, alu_y, ld_word;
  logic [4:0]  dst;
  logic        take_br;
  ctrl_t       ctrl;

  // ---- fetch ----
  assign instr = imem[pc_q[IAW+1:2]];

  always_ff @(posedge clk_i) begin
    if (ld_imem_we_i) imem[ld_addr_i[IAW-1:0]] <= ld_data_i;
  end

  // ---- decode / operands ----
  sc_decode u_dec (
    .op_i    (instr[31:26]),
    .funct_i (instr[5:0]),
    .ctrl_o  (ctrl)
  );

  assign dst     = ctrl.dst_rd ? instr[15:11] : instr[20:16];
  assign imm_ext = ctrl.imm_zext ? {16'h0, instr[15:0]} : {{16{instr[15]}}, instr[15:0]};
  assign alu_b   = ctrl.use_imm ? imm_ext : rt_val;

  sc_regfile #(.NREG(32), .XW(32)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_a_i (instr[25:21]),
    .ra_b_i (instr[20:16]),
    .rd_a_o (rs_val),
    .rd_b_o (rt_val),
    .we_i   (wb_en_o),
    .wa_i   (wb_addr_o),
    .wd_i   (wb_data_o)
  );

  // ---- execute ----
  sc_alu #(.XW(32)) u_alu (
    .op_i    (ctrl.alu_op),
    .a_i     (rs_val),
    .b_i     (alu_b),
    .shamt_i (instr[10:6]),
    .y_o     (alu_y)
  );

  // ---- memory ----
  assign ld_word = dmem[alu_y[DAW+1:2]];

  always_ff @(posedge clk_i) begin
    if (ld_dmem_we_i)  dmem[ld_addr_i[DAW-1:0]] <= ld_data_i;
    else if (st_en_o)  dmem[alu_y[DAW+1:2]]     <= rt_val;
  end

  assign st_en_o   = ctrl.mem_we & rst_ni;
  assign st_addr_o = alu_y;
  assign st_data_o = rt_val;

  // ---- write-back; r0 target dropped here ----
  assign wb_en_o   = ctrl.reg_we & rst_ni & (dst != 5'd0);
  assign wb_addr_o = dst;
  assign wb_data_o = ctrl.mem_rd ? ld_word : alu_y;

  // ---- next PC ----
  assign pc_plus4 = pc_q + 32'd4;
  assign br_tgt   = pc_plus4 + {imm_ext[29:0], 2'b00};
  assign j_tgt    = {pc_plus4[31:28], instr[25:0], 2'b00};
  assign take_br  = (ctrl.br_eq & (rs_val == rt_val)) | (ctrl.br_ne & (rs_val != rt_val));

  always_comb begin
    if (ctrl.jreg)      pc_next = rs_val;
    else if (ctrl.jump) pc_next = j_tgt;
    else if (take_br)   pc_next = br_tgt;
    else                pc_next = pc_plus4;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] pc_q,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic        wb_en_o,
  input logic [4:0]  wb_addr_o,
  input logic        st_en_o
);
  logic [5:0]  op;
  logic        is_beq, is_bne, is_j, is_jr, is_ctl;
  logic [31:0] br_tgt, j_tgt;

  assign op     = instr[31:26];
  assign is_beq = (op == 6'h04);
  assign is_bne = (op == 6'h05);
  assign is_j   = (op == 6'h02);
  assign is_jr  = (op == 6'h00) && (instr[5:0] == 6'h08);
  assign is_ctl = is_beq | is_bne | is_j | is_jr;
  assign br_tgt = pc_q + 32'd4 + {{14{instr[15]}}, instr[15:0], 2'b00};
  assign j_tgt  = {pc_q[31:28] + {3'b0, &pc_q[27:2]}, instr[25:0], 2'b00};

  AST_SEQ_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_ctl |=> pc_q == $past(pc_q) + 32'd4); // R2

  AST_BEQ_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_beq && rs_val == rt_val) |=> pc_q == $past(br_tgt)); // R9

  AST_BNE_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_bne && rs_val == rt_val) |=> pc_q == $past(pc_q) + 32'd4); // R9

  AST_J_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_j |=> pc_q == $past(j_tgt)); // R10

  AST_JR_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_jr |=> pc_q == $past(rs_val)); // R11

  AST_NO_WB_ON_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_en_o |-> !wb_en_o); // R7

  AST_NO_R0_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> wb_addr_o != 5'd0); // R8

  AST_R0_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr[25:21] == 5'd0) |-> rs_val == 32'd0); // R8
endmodule

bind sc_core sc_core_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pc_q      (pc_q),
  .instr     (instr),
  .rs_val    (rs_val),
  .rt_val    (rt_val),
  .wb_en_o   (wb_en_o),
  .wb_addr_o (wb_addr_o),
  .st_en_o   (st_en_o)
);

// File: tb/sim_sc_core.sv
module sim_sc_core;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 64;
  localparam int AW = 6;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ld_imem_we_i = 1'b0, ld_dmem_we_i = 1'b0;
  logic [AW-1:0] ld_addr_i = '0;
  logic [31:0]   ld_data_i = '0;
  logic [31:0]   pc_o, wb_data_o, st_addr_o, st_data_o;
  logic          wb_en_o, st_en_o;
  logic [4:0]    wb_addr_o;

  sc_core u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  logic [31:0] prog [NW];
  logic [31:0] sh_reg [32];
  logic [31:0] pc_tr [NW];
  logic [31:0] st_a, st_d;
  int          st_cnt;
  logic        r0_wb;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < NW; i++) prog[i] = 32'h0;
  endtask

  task automatic load_mem(bit to_dmem, int idx, logic [31:0] w);
    @(negedge clk_i);
    ld_imem_we_i = !to_dmem;
    ld_dmem_we_i = to_dmem;
    ld_addr_i    = AW'(idx);
    ld_data_i    = w;
    @(negedge clk_i);
    ld_imem_we_i = 1'b0;
    ld_dmem_we_i = 1'b0;
  endtask

  task automatic enter_reset_and_load();
    rst_ni = 1'b0;
    for (int i = 0; i < NW; i++) load_mem(1'b0, i, prog[i]);
  endtask

  task automatic run(int ncyc);
    for (int i = 0; i < 32; i++) sh_reg[i] = 32'h0;
    st_cnt = 0; r0_wb = 1'b0; st_a = 'x; st_d = 'x;
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    for (int k = 0; k < ncyc; k++) begin
      pc_tr[k] = pc_o;
      if (wb_en_o) begin
        if (wb_addr_o == 5'd0) r0_wb = 1'b1;
        sh_reg[wb_addr_o] = wb_data_o;
      end
      if (st_en_o) begin
        st_cnt++; st_a = st_addr_o; st_d = st_data_o;
      end
      @(negedge clk_i);
      #1;
    end
  endtask

  task automatic t_reset();
    clear_prog();
    prog[0] = enc_i(6'h08, 0, 1, 16'h55);          // addi r1,r0,0x55
    prog[1] = enc_i(6'h2B, 0, 1, 0);               // sw r1,0(r0)
    enter_reset_and_load();
    #1;
    check("R1 pc in reset", pc_o, 32'h0);
    check("R1 wb_en in reset", {31'h0, wb_en_o}, 32'h0);
    check("R1 st_en in reset", {31'h0, st_en_o}, 32'h0);
    run(4);
    check("R1 first pc", pc_tr[0], 32'h0);
    check("R2 pc step 1", pc_tr[1], 32'h4);
    check("R2 pc step 3", pc_tr[3], 32'hC);
    check("R1 first instr result", sh_reg[1], 32'h55);
  endtask

  task automatic t_alu();
    clear_prog();
    prog[0] = enc_i(6'h08, 0, 1, 5);               // addi r1 = 5
    prog[1] = enc_i(6'h08, 0, 2, -3);              // addi r2 = -3
    prog[2] = enc_r(1, 2, 3, 0, 6'h20);            // add
    prog[3] = enc_r(1, 2, 4, 0, 6'h22);            // sub
    prog[4] = enc_r(1, 2, 5, 0, 6'h24);            // and
    prog[5] = enc_r(1, 2, 6, 0, 6'h25);            // or
    prog[6] = enc_r(1, 2, 7, 0, 6'h27);            // nor
    prog[7] = enc_r(2, 1, 8, 0, 6'h2A);            // slt -3<5
    prog[8] = enc_r(1, 2, 9, 0, 6'h2A);            // slt 5<-3
    prog[9] = enc_r(1, 1, 10, 0, 6'h2A);           // slt 5<5
    enter_reset_and_load();
    run(12);
    check("R6 addi sext", sh_reg[2], 32'hFFFF_FFFD);
    check("R3 add", sh_reg[3], 32'h2);
    check("R3 sub", sh_reg[4], 32'h8);
    check("R3 and", sh_reg[5], 32'h5);
    check("R3 or", sh_reg[6], 32'hFFFF_FFFD);
    check("R3 nor", sh_reg[7], 32'h2);
    check("R4 slt neg<pos", sh_reg[8], 32'h1);
    check("R4 slt pos<neg", sh_reg[9], 32'h0);
    check("R4 slt equal", sh_reg[10], 32'h0);
  endtask

  task automatic t_shift_imm();
    clear_prog();
    prog[0] = enc_i(6'h0D, 0, 1, 16'h8001);        // ori zext
    prog[1] = enc_i(6'h0C, 1, 2, 16'h800F);        // andi zext
    prog[2] = enc_i(6'h08, 0, 3, 16'h8000);        // addi sext
    prog[3] = enc_r(0, 3, 4, 4, 6'h00);            // sll
    prog[4] = enc_r(0, 3, 5, 4, 6'h02);            // srl
    prog[5] = enc_r(0, 1, 6, 31, 6'h00);           // sll by 31
    enter_reset_and_load();
    run(8);
    check("R6 ori zext", sh_reg[1], 32'h0000_8001);
    check("R6 andi zext", sh_reg[2], 32'h0000_8001);
    check("R6 addi neg", sh_reg[3], 32'hFFFF_8000);
    check("R5 sll", sh_reg[4], 32'hFFF8_0000);
    check("R5 srl logical", sh_reg[5], 32'h0FFF_F800);
    check("R5 sll 31", sh_reg[6], 32'h8000_0000);
  endtask

  task automatic t_mem();
    clear_prog();
    prog[0] = enc_i(6'h08, 0, 1, 16);              // r1 = 16
    prog[1] = enc_i(6'h23, 1, 2, -4);              // lw r2,-4(r1) -> word 3
    prog[2] = enc_i(6'h23, 1, 3, -8);              // lw r3,-8(r1) -> word 2
    prog[3] = enc_r(2, 3, 4, 0, 6'h20);            // r4 = r2+r3
    prog[4] = enc_i(6'h2B, 1, 4, 4);               // sw r4,4(r1) -> addr 20
    prog[5] = enc_i(6'h23, 1, 5, 4);               // lw r5,4(r1)
    enter_reset_and_load();
    load_mem(1'b1, 3, 32'hCAFE_F00D);
    load_mem(1'b1, 2, 32'h0000_0011);
    run(8);
    check("R12 R7 lw neg offset", sh_reg[2], 32'hCAFE_F00D);
    check("R12 R7 lw word 2", sh_reg[3], 32'h0000_0011);
    check("R7 store count", 32'(st_cnt), 32'd1);
    check("R7 store addr", st_a, 32'd20);
    check("R7 store data", st_d, 32'hCAFE_F01E);
    check("R7 lw after sw", sh_reg[5], 32'hCAFE_F01E);
  endtask

  task automatic t_r0();
    clear_prog();
    prog[0] = enc_i(6'h08, 0, 0, 7);               // addi r0,r0,7
    prog[1] = enc_i(6'h0D, 0, 0, 16'hFFFF);        // ori r0
    prog[2] = enc_r(0, 0, 1, 0, 6'h20);            // r1 = r0+r0
    prog[3] = enc_i(6'h2B, 0, 0, 8);               // sw r0,8(r0)
    enter_reset_and_load();
    run(5);
    check("R8 r0 reads zero", sh_reg[1], 32'h0);
    check("R8 no r0 writeback", {31'h0, r0_wb}, 32'h0);
    check("R8 store of r0", st_d, 32'h0);
  endtask

  task automatic t_branch();
    clear_prog();
    prog[0]  = enc_i(6'h08, 0, 1, 1);
    prog[1]  = enc_i(6'h08, 0, 2, 1);
    prog[2]  = enc_i(6'h04, 1, 2, 2);              // beq taken -> 20
    prog[3]  = enc_i(6'h08, 0, 3, 1);
    prog[4]  = enc_i(6'h08, 0, 3, 2);
    prog[5]  = enc_i(6'h08, 0, 4, 9);              // @20
    prog[6]  = enc_i(6'h05, 1, 2, 5);              // bne not taken
    prog[7]  = enc_i(6'h05, 1, 0, 1);              // bne taken -> 36
    prog[8]  = enc_i(6'h08, 0, 5, 1);
    prog[9]  = enc_i(6'h08, 0, 6, 3);              // @36
    prog[10] = enc_i(6'h04, 0, 0, -11);            // beq back -> 0
    enter_reset_and_load();
    run(10);
    check("R9 beq taken", pc_tr[3], 32'd20);
    check("R9 bne fall", pc_tr[5], 32'd28);
    check("R9 bne taken", pc_tr[6], 32'd36);
    check("R9 beq backward", pc_tr[8], 32'd0);
    check("R9 skipped r3", sh_reg[3], 32'h0);
    check("R9 skipped r5", sh_reg[5], 32'h0);
    check("R9 target ran", sh_reg[6], 32'h3);
  endtask

  task automatic t_jump();
    clear_prog();
    prog[0] = enc_i(6'h02, 0, 0, 4) | 32'h0;       // j -> 16
    prog[1] = enc_i(6'h08, 0, 1, 1);
    prog[4] = enc_i(6'h08, 0, 2, 32);              // @16
    prog[5] = enc_r(2, 0, 0, 0, 6'h08);            // jr r2 -> 32
    prog[6] = enc_i(6'h08, 0, 4, 1);
    prog[8] = enc_i(6'h08, 0, 3, 1);               // @32
    enter_reset_and_load();
    run(5);
    check("R10 j target", pc_tr[1], 32'd16);
    check("R11 jr target", pc_tr[3], 32'd32);
    check("R10 skipped", sh_reg[1], 32'h0);
    check("R11 skipped", sh_reg[4], 32'h0);
    check("R11 target ran", sh_reg[3], 32'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_alu();
    t_shift_imm();
    t_mem();
    t_r0();
    t_branch();
    t_jump();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule